// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block produces the column address for each beat of one SDRAM read or write burst. A controller pulses a start strobe with an 8-bit starting column, a burst length code and an ordering select. The generator then presents one column per clock until the burst ends. A burst ends in one of three ways: it reaches its programmed length, a terminate strobe cuts it off, or a new start replaces it.

Fixed-length bursts of 1, 2, 4 or 8 beats stay inside the aligned block that holds the start column. The order inside that block is either a wrapping count or an XOR order. A full-page burst walks through every column modulo 256 until a terminate strobe stops it. A done pulse marks the last beat of a fixed-length burst, so the controller can start an auto-precharge on time. Forming commands and moving data belong to other blocks.

Top module: `burst_col_gen`

## Requirements
- R1: When start_i is sampled high on a rising edge, the next cycle shows valid_o high and col_o equal to the start_col_i value sampled on that edge (beat 0).
- R2: Length codes 0, 1, 2 and 3 give bursts of 1, 2, 4 and 8 beats. Each later beat appears one cycle after the previous one, and valid_o stays high for every beat.
- R3: With ordering select low (sequential), beat n is formed from the start column as follows: the low log2(L) bits are replaced by the low log2(L) bits of (start + n), and the upper bits are kept.
- R4: With ordering select high (interleaved), beat n of a fixed-length burst is the start column with its low log2(L) bits XORed with n.
- R5: Length codes 4 to 7 select a full page. Beat n is (start + n) mod 256, the ordering select has no effect, and done_o never goes high.
- R6: In a fixed-length burst, done_o is high exactly on the last beat, and valid_o is low in the following cycle unless a new start arrived. A 1-beat burst raises done_o on its only beat.
- R7: When term_i is sampled high without start_i, valid_o and done_o are low from the next cycle onward, and the cut-off burst never raises done_o.
- R8: A start sampled during a burst in progress replaces it at once, and beat 0 of the new burst follows in the next cycle. When start_i and term_i are sampled on the same edge, the start wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a new burst |
| start_col_i | input | 8 | Starting column |
| len_code_i | input | 3 | 0..3: 1/2/4/8 beats; 4..7: full page |
| ilv_i | input | 1 | 1 = interleaved order, 0 = sequential |
| term_i | input | 1 | Cut off the burst in progress |
| col_o | output | 8 | Column for the current beat |
| valid_o | output | 1 | col_o holds a beat |
| done_o | output | 1 | Last beat of a fixed-length burst |

## Verification
Beat 0 appears in the cycle after the edge that samples start_i, and beat n appears n cycles after that. done_o lines up with the last beat. After a terminate, valid_o is low one cycle after the sampling edge. The bench changes inputs on falling edges and compares every output on the next falling edge, so each beat is checked in the cycle it is due. The expected column for beat n comes from the sequential, XOR and modulo-256 rules in the requirements. When a burst has ended, the bench checks that valid_o has fallen and stays low.

// File: rtl/burst_pkg.sv
package burst_pkg;
  localparam int unsigned LEN_CODE_W = 3;

  typedef enum logic {
    ORD_SEQ = 1'b0,
    ORD_ILV = 1'b1
  } order_e;
endpackage

// File: rtl/burst_len_decode.sv
module burst_len_decode #(
  parameter int unsigned COL_W     = 8,
  parameter int unsigned FIXED_MAX = 3
) (
  input  logic [burst_pkg::LEN_CODE_W-1:0] code_i,
  output logic [COL_W-1:0]                 mask_o,
  output logic                             full_o
);
  assign full_o = int'(code_i) > int'(FIXED_MAX);

  // mask covers the bits that move inside the burst block
  for (genvar i = 0; i < COL_W; i++) begin : g_mask
    assign mask_o[i] = full_o | (int'(code_i) > i);
  end
endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr #(
  parameter int unsigned COL_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic                term_i,
  input  logic [COL_W-1:0]    start_col_i,
  input  logic [COL_W-1:0]    mask_i,
  input  logic                full_i,
  input  burst_pkg::order_e   order_i,
  output logic                active_o,
  output logic                last_o,
  output logic [COL_W-1:0]    beat_o,
  output logic [COL_W-1:0]    base_o,
  output logic [COL_W-1:0]    mask_o,
  output logic                full_o,
  output burst_pkg::order_e   order_o
);
  logic             active_q;
  logic [COL_W-1:0] beat_q, base_q, mask_q;
  logic             full_q;
  burst_pkg::order_e order_q;

  assign last_o = active_q & ~full_q & (beat_q == mask_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      beat_q   <= '0;
      base_q   <= '0;
      mask_q   <= '0;
      full_q   <= 1'b0;
      order_q  <= burst_pkg::ORD_SEQ;
    end else if (start_i) begin
      active_q <= 1'b1;
      beat_q   <= '0;
      base_q   <= start_col_i;
      mask_q   <= mask_i;
      full_q   <= full_i;
      order_q  <= full_i ? burst_pkg::ORD_SEQ : order_i;
    end else if (term_i) begin
      active_q <= 1'b0;
    end else if (active_q) begin
      if (last_o) active_q <= 1'b0;
      else        beat_q   <= beat_q + 1'b1;
    end
  end

  assign active_o = active_q;
  assign beat_o   = beat_q;
  assign base_o   = base_q;
  assign mask_o   = mask_q;
  assign full_o   = full_q;
  assign order_o  = order_q;
endmodule

// File: rtl/burst_col_map.sv
module burst_col_map #(
  parameter int unsigned COL_W = 8
) (
  input  logic [COL_W-1:0]  base_i,
  input  logic [COL_W-1:0]  beat_i,
  input  logic [COL_W-1:0]  mask_i,
  input  burst_pkg::order_e order_i,
  output logic [COL_W-1:0]  col_o
);
  logic [COL_W-1:0] sum;
  logic [COL_W-1:0] seq_col, ilv_col;

  assign sum     = base_i + beat_i;
  assign seq_col = (base_i & ~mask_i) | (sum & mask_i);
  assign ilv_col = base_i ^ (beat_i & mask_i);

  always_comb begin
    unique case (order_i)
      burst_pkg::ORD_ILV: col_o = ilv_col;
      default:            col_o = seq_col;
    endcase
  end
endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen #(
  parameter int unsigned COL_W     = 8,
  parameter int unsigned FIXED_MAX = 3
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             start_i,
  input  logic [COL_W-1:0]                 start_col_i,
  input  logic [burst_pkg::LEN_CODE_W-1:0] len_code_i,
  input  logic                             ilv_i,
  input  logic                             term_i,
  output logic [COL_W-1:0]                 col_o,
  output logic                             valid_o,
  output logic                             done_o
);
  logic [COL_W-1:0]  dec_mask, beat, base, cfg_mask;
  logic              dec_full, cfg_full, active, last;
  burst_pkg::order_e cfg_order, in_order;

  assign in_order = ilv_i ? burst_pkg::ORD_ILV : burst_pkg::ORD_SEQ;

  burst_len_decode #(.COL_W(COL_W), .FIXED_MAX(FIXED_MAX)) i_dec (
    .code_i (len_code_i),
    .mask_o (dec_mask),
    .full_o (dec_full)
  );

  burst_beat_ctr #(.COL_W(COL_W)) i_ctr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .term_i      (term_i),
    .start_col_i (start_col_i),
    .mask_i      (dec_mask),
    .full_i      (dec_full),
    .order_i     (in_order),
    .active_o    (active),
    .last_o      (last),
    .beat_o      (beat),
    .base_o      (base),
    .mask_o      (cfg_mask),
    .full_o      (cfg_full),
    .order_o     (cfg_order)
  );

  burst_col_map #(.COL_W(COL_W)) i_map (
    .base_i  (base),
    .beat_i  (beat),
    .mask_i  (cfg_mask),
    .order_i (cfg_order),
    .col_o   (col_o)
  );

  assign valid_o = active;
  assign done_o  = last;
endmodule

// File: rtl/burst_col_gen_chk.sv
module burst_col_gen_chk #(
  parameter int unsigned COL_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             term_i,
  input logic [COL_W-1:0] start_col_i,
  input logic [COL_W-1:0] col_o,
  input logic             valid_o,
  input logic             done_o,
  input logic             full_i
);
  assert_start_loads_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> valid_o && col_o == $past(start_col_i));

  assert_burst_holds_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !done_o && !start_i && !term_i |=> valid_o);

  assert_full_no_done_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_i && valid_o |-> !done_o);

  assert_done_in_burst_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> valid_o);

  assert_done_ends_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !start_i |=> !valid_o);

  assert_term_stops_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    term_i && !start_i |=> !valid_o && !done_o);

  assert_start_wins_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && term_i |=> valid_o);
endmodule

bind burst_col_gen burst_col_gen_chk #(.COL_W(COL_W)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .term_i      (term_i),
  .start_col_i (start_col_i),
  .col_o       (col_o),
  .valid_o     (valid_o),
  .done_o      (done_o),
  .full_i      (cfg_full)
);

// File: tb/test_burst_col_gen.sv
module test_burst_col_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [7:0] scol = '0;
  logic [2:0] code = '0;
  logic       ilv = 1'b0;
  logic       term = 1'b0;
  logic [7:0] col;
  logic       valid, done;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  burst_col_gen i_burst_col_gen (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .start_col_i(scol),
    .len_code_i(code), .ilv_i(ilv), .term_i(term),
    .col_o(col), .valid_o(valid), .done_o(done)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_col(logic [7:0] s, int c, bit il, int n);
    logic [7:0] m;
    if (c > 3) return 8'(int'(s) + n);
    m = 8'((1 << c) - 1);
    if (il) return s ^ (8'(n) & m);
    return (s & ~m) | (8'(int'(s) + n) & m);
  endfunction

  task automatic launch(input logic [7:0] s, input int c, input bit il);
    start = 1'b1; scol = s; code = 3'(c); ilv = il;
    @(negedge clk);
    start = 1'b0;
  endtask

  // checks beats 0..k-1; sets term on the last checked beat if asked
  task automatic run_beats(input logic [7:0] s, input int c, input bit il,
                           input int k, input bit fixed_end, input bit cut);
    int len = (c > 3) ? 0 : (1 << c);
    string oreq = (c > 3) ? "R5" : (il ? "R4" : "R3");
    for (int n = 0; n < k; n++) begin
      chk(valid === 1'b1, (n == 0) ? "R1" : "R2", "valid", int'(valid), 1);
      chk(col === exp_col(s, c, il, n), (n == 0) ? "R1" : oreq, "col",
          int'(col), int'(exp_col(s, c, il, n)));
      if (c > 3) chk(done === 1'b0, "R5", "done", int'(done), 0);
      else chk(done === ((fixed_end && n == len - 1) ? 1'b1 : 1'b0), "R6",
               "done", int'(done), (fixed_end && n == len - 1) ? 1 : 0);
      if (cut && n == k - 1) term = 1'b1;
      @(negedge clk);
    end
    term = 1'b0;
  endtask

  task automatic t_reset();
    chk(valid === 1'b0, "R1", "reset valid", int'(valid), 0);
    chk(done === 1'b0, "R6", "reset done", int'(done), 0);
  endtask

  task automatic t_fixed(input logic [7:0] s, input int c, input bit il);
    launch(s, c, il);
    run_beats(s, c, il, 1 << c, 1'b1, 1'b0);
    chk(valid === 1'b0, "R6", "valid after last", int'(valid), 0);
    chk(done === 1'b0, "R6", "done after last", int'(done), 0);
  endtask

  task automatic t_full(input logic [7:0] s, input bit il, input int k);
    launch(s, 7 - 3 * int'(il), il);
    run_beats(s, 7 - 3 * int'(il), il, k, 1'b0, 1'b1);
    chk(valid === 1'b0, "R7", "valid after term", int'(valid), 0);
    chk(done === 1'b0, "R7", "done after term", int'(done), 0);
  endtask

  task automatic t_term(input logic [7:0] s, input int k);
    launch(s, 3, 1'b0);
    run_beats(s, 3, 1'b0, k, 1'b0, 1'b1);
    for (int i = 0; i < 10; i++) begin
      chk(valid === 1'b0, "R7", "valid after cut", int'(valid), 0);
      chk(done === 1'b0, "R7", "done after cut", int'(done), 0);
      @(negedge clk);
    end
  endtask

  task automatic t_preempt(input logic [7:0] s1, input logic [7:0] s2, input bit with_term);
    launch(s1, 3, 1'b1);
    run_beats(s1, 3, 1'b1, 2, 1'b0, 1'b0);
    chk(col === exp_col(s1, 3, 1'b1, 2), "R8", "beat before preempt",
        int'(col), int'(exp_col(s1, 3, 1'b1, 2)));
    term = with_term;
    launch(s2, 2, 1'b0);
    term = 1'b0;
    run_beats(s2, 2, 1'b0, 4, 1'b1, 1'b0);
    chk(valid === 1'b0, "R8", "valid after new burst", int'(valid), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fixed(8'h5a, 0, 1'b0);
    t_fixed(8'h5a, 0, 1'b1);
    t_fixed(8'h11, 1, 1'b0);
    t_fixed(8'h35, 2, 1'b0);
    t_fixed(8'h35, 2, 1'b1);
    t_fixed(8'hfe, 3, 1'b0);
    t_fixed(8'h2b, 3, 1'b1);
    t_fixed(8'h80, 3, 1'b0);
    t_full(8'hfc, 1'b0, 300);
    t_full(8'h03, 1'b1, 20);
    t_term(8'h44, 3);
    t_term(8'h47, 1);
    t_preempt(8'h2b, 8'hc6, 1'b0);
    t_preempt(8'h10, 8'h9d, 1'b1);
    // back-to-back bursts with no idle cycle
    start = 1'b1; scol = 8'h70; code = 3'd1; ilv = 1'b0;
    @(negedge clk);
    scol = 8'h71;
    chk(col === 8'h70 && done === 1'b0, "R2", "b2b first beat", int'(col), 'h70);
    @(negedge clk);
    start = 1'b0;
    run_beats(8'h71, 1, 1'b0, 2, 1'b1, 1'b0);
    chk(valid === 1'b0, "R6", "b2b end", int'(valid), 0);
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule